// File: doc/BRIEF.md
# Smart Card Warm Reset Sequencer

This block runs a warm reset on one smart-card slot. The slot must already be powered and working in asynchronous mode. Everything runs on the card clock. Software requests a warm reset with a one-cycle strobe, and the block then takes over the card reset line. It pulls reset low for a fixed number of card clocks and then releases it. While it does this, it watches the card IO line for the first falling edge, which marks the start of the answer-to-reset.

When that edge arrives, it is compared against three windows:

- **Blanking window.** For a fixed number of clocks right after reset falls, IO activity is ignored.
- **Reset-low fault.** A falling edge after the blanking window but while reset is still low counts as both an early fault and a mute fault.
- **Threshold windows.** Once reset is high, a counter runs. An edge before the 16-bit early threshold is an early fault. An edge between the early threshold and the 16-bit mute threshold is a normal answer and sets no flag. If the counter reaches the mute threshold with no edge, that is a mute fault.

Each threshold arrives as a high byte and a low byte.

The fault flags are sticky and appear in a status byte. An active-low interrupt stays asserted while either flag is set. A read-clear strobe from the register interface clears both flags. The supply, the card clock and the decoding of the answer bytes are handled elsewhere.

Top module: `scwr_warm_reset`

## Requirements
- R1: After reset: `cardRst` is 1, `busy` is 0, `statusByte` is 0x00 and `intN` is 1.
- R2: A `warmReq` pulse is accepted only when `ifActive` is 1 and `busy` is 0. On the next clock edge after acceptance, `cardRst` goes to 0 and `busy` goes to 1. A request with `ifActive` at 0, or a request while `busy` is 1, changes nothing.
- R3: `cardRst` stays low for exactly `RST_LOW_CYCLES` clock cycles and then returns to 1.
- R4: An IO falling edge is judged at the third rising clock edge after it reaches `ioIn` (two synchronizer flops plus one edge register). The sequence counter is 0 during the first cycle after `cardRst` changes and increases by one every cycle. An edge judged while `cardRst` is low and the counter is below `BLANK_CYCLES` is ignored.
- R5: An edge judged while `cardRst` is low and the counter is `BLANK_CYCLES` or more sets both the early and the mute flag. `cardRst` still returns high at the normal time, and `busy` falls on that same edge.
- R6: An edge judged after `cardRst` has risen, with the counter below the early threshold (`{earlyHi,earlyLo}`), sets only the early flag and ends the sequence.
- R7: An edge judged with the counter at or above the early threshold but below the mute threshold (`{muteHi,muteLo}`) sets no flag and ends the sequence.
- R8: If the counter equals the mute threshold, the mute flag is set and the sequence ends. This holds even if an edge is judged in that same cycle. With no edge at all, the mute flag appears `mute+1` cycles after `cardRst` rises.
- R9: Both flags are sticky until a `statusClr` cycle. A flag being set takes priority over a clear in the same cycle. `intN` is 0 exactly while either flag is 1.
- R10: In `statusByte`, bit 6 is the early flag and bit 5 is the mute flag. All other bits are 0.
- R11: Only the first qualifying edge decides the result. IO activity after the decision leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ifActive | input | 1 | Slot is powered and in asynchronous mode |
| warmReq | input | 1 | Write strobe of the warm-reset control bit |
| earlyHi | input | 8 | Early threshold, high byte |
| earlyLo | input | 8 | Early threshold, low byte |
| muteHi | input | 8 | Mute threshold, high byte |
| muteLo | input | 8 | Mute threshold, low byte |
| ioIn | input | 1 | Card IO line, asynchronous |
| statusClr | input | 1 | Read-clear strobe for the status flags |
| cardRst | output | 1 | Card reset line |
| busy | output | 1 | Sequence in progress |
| statusByte | output | 8 | Status: bit 6 early, bit 5 mute |
| intN | output | 1 | Active-low interrupt |

## Verification
The assertions check the following on every cycle:

- Reset can only fall from an idle, accepted request.
- `busy` covers the whole reset-low interval.
- A flag raised while reset is low always comes with the mute flag.
- Flags rise only inside a sequence and stay set until cleared.
- The interrupt tracks the flags.

Some behaviour depends on where an IO edge lands relative to the counter, so only the bench scenarios can show it. These are the exact reset-low length, the blanking boundary, the early and mute threshold boundaries including the tie at the mute count, and the mute timeout latency.

// File: rtl/scwr_pkg.sv
package scwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RSTLOW = 2'd1,
    ST_ATR    = 2'd2
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic rstDriveLow;
    logic rstDriveHigh;
    logic setEarly;
    logic setMute;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic ioFall;
    logic blankOver;
    logic rstLowDone;
    logic beforeEarly;
    logic muteReached;
  } seqCond_t;

endpackage

// File: rtl/scwr_datapath.sv
module scwr_datapath
  import scwr_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES   = 200,
  parameter int unsigned RST_LOW_CYCLES = 42100,
  parameter int unsigned TH_W           = 16,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioIn,
  input  logic             statusClr,
  input  logic [TH_W-1:0]  earlyLim,
  input  logic [TH_W-1:0]  muteLim,
  input  seqStrobe_t       strobe,
  output seqCond_t         cond,
  output logic             cardRst,
  output logic             earlyFlag,
  output logic             muteFlag
);
  localparam int unsigned RL_W  = $clog2(RST_LOW_CYCLES + 1);
  localparam int unsigned CNT_W = (RL_W > TH_W) ? RL_W : TH_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   ioPrev;
  logic [CNT_W-1:0]       cnt;

  // IO synchronizer, idle level high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= ioIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ioIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) ioPrev <= 1'b1;
    else       ioPrev <= syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else                    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                    cardRst <= 1'b1;
    else if (strobe.rstDriveLow)  cardRst <= 1'b0;
    else if (strobe.rstDriveHigh) cardRst <= 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                earlyFlag <= 1'b0;
    else if (strobe.setEarly) earlyFlag <= 1'b1;
    else if (statusClr)       earlyFlag <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               muteFlag <= 1'b0;
    else if (strobe.setMute) muteFlag <= 1'b1;
    else if (statusClr)      muteFlag <= 1'b0;

  always_comb begin
    cond.ioFall      = ioPrev & ~syncQ[SYNC_STAGES-1];
    cond.blankOver   = cnt >= CNT_W'(BLANK_CYCLES);
    cond.rstLowDone  = cnt == CNT_W'(RST_LOW_CYCLES - 1);
    cond.beforeEarly = cnt <  CNT_W'(earlyLim);
    cond.muteReached = cnt == CNT_W'(muteLim);
  end

endmodule

// File: rtl/scwr_control.sv
module scwr_control
  import scwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       warmReq,
  input  logic       ifActive,
  input  seqCond_t   cond,
  output seqStrobe_t strobe,
  output logic       busy
);
  seqState_t state, nextState;
  logic      decided, nextDecided;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state   <= ST_IDLE;
      decided <= 1'b0;
    end else begin
      state   <= nextState;
      decided <= nextDecided;
    end

  always_comb begin
    strobe      = '0;
    nextState   = state;
    nextDecided = decided;
    unique case (state)
      ST_IDLE: begin
        strobe.cntClr = 1'b1;
        if (warmReq && ifActive) begin
          strobe.rstDriveLow = 1'b1;
          nextDecided        = 1'b0;
          nextState          = ST_RSTLOW;
        end
      end
      ST_RSTLOW: begin
        if (!decided && cond.ioFall && cond.blankOver) begin
          strobe.setEarly = 1'b1;
          strobe.setMute  = 1'b1;
          nextDecided     = 1'b1;
        end
        if (cond.rstLowDone) begin
          strobe.rstDriveHigh = 1'b1;
          strobe.cntClr       = 1'b1;
          nextState           = nextDecided ? ST_IDLE : ST_ATR;
        end
      end
      ST_ATR: begin
        if (cond.muteReached) begin
          strobe.setMute = 1'b1;
          strobe.cntClr  = 1'b1;
          nextState      = ST_IDLE;
        end else if (cond.ioFall) begin
          strobe.setEarly = cond.beforeEarly;
          strobe.cntClr   = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/scwr_warm_reset.sv
module scwr_warm_reset
  import scwr_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES   = 200,
  parameter int unsigned RST_LOW_CYCLES = 42100,
  parameter int unsigned BYTE_W         = 8,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifActive,
  input  logic              warmReq,
  input  logic [BYTE_W-1:0] earlyHi,
  input  logic [BYTE_W-1:0] earlyLo,
  input  logic [BYTE_W-1:0] muteHi,
  input  logic [BYTE_W-1:0] muteLo,
  input  logic              ioIn,
  input  logic              statusClr,
  output logic              cardRst,
  output logic              busy,
  output logic [7:0]        statusByte,
  output logic              intN
);
  localparam int unsigned TH_W      = 2 * BYTE_W;
  localparam int unsigned EARLY_BIT = 6;
  localparam int unsigned MUTE_BIT  = 5;

  seqStrobe_t strobe;
  seqCond_t   cond;
  logic       earlyFlag, muteFlag;

  scwr_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .warmReq  (warmReq),
    .ifActive (ifActive),
    .cond     (cond),
    .strobe   (strobe),
    .busy     (busy)
  );

  scwr_datapath #(
    .BLANK_CYCLES   (BLANK_CYCLES),
    .RST_LOW_CYCLES (RST_LOW_CYCLES),
    .TH_W           (TH_W),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ioIn      (ioIn),
    .statusClr (statusClr),
    .earlyLim  ({earlyHi, earlyLo}),
    .muteLim   ({muteHi, muteLo}),
    .strobe    (strobe),
    .cond      (cond),
    .cardRst   (cardRst),
    .earlyFlag (earlyFlag),
    .muteFlag  (muteFlag)
  );

  always_comb begin
    statusByte            = '0;
    statusByte[EARLY_BIT] = earlyFlag;
    statusByte[MUTE_BIT]  = muteFlag;
  end

  assign intN = ~(earlyFlag | muteFlag);

endmodule

// File: rtl/scwr_checker.sv
module scwr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ifActive,
  input logic       warmReq,
  input logic       statusClr,
  input logic       cardRst,
  input logic       busy,
  input logic [7:0] statusByte,
  input logic       intN
);
  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardRst) |-> $past(!busy && warmReq && ifActive));

  // R3
  rst_low_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cardRst |-> busy);

  // R5
  both_flags_rstlow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cardRst && $rose(statusByte[6])) |-> statusByte[5]);

  // R6
  early_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[6]) |-> $past(busy));

  // R8
  mute_in_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[5]) |-> $past(busy));

  // R9
  early_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] && !statusClr) |=> statusByte[6]);

  // R9
  mute_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] && !statusClr) |=> statusByte[5]);

  // R9
  int_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] || statusByte[5]) |-> !intN);

  // R9
  int_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[6] && !statusByte[5]) |-> intN);
endmodule

bind scwr_warm_reset scwr_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ifActive   (ifActive),
  .warmReq    (warmReq),
  .statusClr  (statusClr),
  .cardRst    (cardRst),
  .busy       (busy),
  .statusByte (statusByte),
  .intN       (intN)
);

// File: tb/scwr_warm_reset_tb.sv
module scwr_warm_reset_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 6;
  localparam int RSTLOW     = 30;
  localparam int WDOG       = 150000;

  typedef struct packed {
    logic        ph;     // 0: edge while reset low, 1: after reset high
    logic        drive;  // 0: no IO edge
    logic [7:0]  d;      // delay; edge judged at counter d+2
    logic [15:0] early;
    logic [15:0] mute;
    logic        expE;
    logic        expM;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'd2,  16'd10, 16'd20, 1'b1, 1'b0},  // R6 cnt 4
    '{1'b1, 1'b1, 8'd7,  16'd10, 16'd20, 1'b1, 1'b0},  // R6 cnt 9 boundary
    '{1'b1, 1'b1, 8'd8,  16'd10, 16'd20, 1'b0, 1'b0},  // R7 cnt 10
    '{1'b1, 1'b1, 8'd17, 16'd10, 16'd20, 1'b0, 1'b0},  // R7 cnt 19
    '{1'b1, 1'b0, 8'd0,  16'd10, 16'd20, 1'b0, 1'b1},  // R8 no edge
    '{1'b0, 1'b1, 8'd4,  16'd10, 16'd20, 1'b1, 1'b1},  // R5 cnt 6
    '{1'b0, 1'b1, 8'd3,  16'd10, 16'd20, 1'b0, 1'b1},  // R4 cnt 5 blanked
    '{1'b1, 1'b1, 8'd18, 16'd10, 16'd20, 1'b0, 1'b1},  // R8 tie at mute
    '{1'b1, 1'b1, 8'd0,  16'd0,  16'd5,  1'b0, 1'b0},  // R7 early 0
    '{1'b1, 1'b1, 8'd5,  16'd30, 16'd12, 1'b1, 1'b0}   // R6 early above mute
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ifActive = 1'b1;
  logic       warmReq = 1'b0;
  logic [7:0] earlyHi = '0, earlyLo = 8'd10, muteHi = '0, muteLo = 8'd20;
  logic       ioIn = 1'b1;
  logic       statusClr = 1'b0;
  logic       cardRst, busy, intN;
  logic [7:0] statusByte;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scwr_warm_reset #(
    .BLANK_CYCLES   (BLANK),
    .RST_LOW_CYCLES (RSTLOW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ifActive(ifActive), .warmReq(warmReq),
    .earlyHi(earlyHi), .earlyLo(earlyLo), .muteHi(muteHi), .muteLo(muteLo),
    .ioIn(ioIn), .statusClr(statusClr), .cardRst(cardRst), .busy(busy),
    .statusByte(statusByte), .intN(intN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearStatus();
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic startSeq();
    @(negedge clk); warmReq = 1'b1;
    @(negedge clk); warmReq = 1'b0;
  endtask

  task automatic pulseIo(input int d);
    repeat (d) @(posedge clk);
    @(negedge clk); ioIn = 1'b0;
    repeat (3) @(negedge clk);
    ioIn = 1'b1;
  endtask

  task automatic runVec(input vec_t v, input int idx);
    earlyHi = v.early[15:8]; earlyLo = v.early[7:0];
    muteHi  = v.mute[15:8];  muteLo  = v.mute[7:0];
    clearStatus();
    startSeq();
    if (v.ph) while (!cardRst) @(negedge clk);
    if (v.drive) pulseIo(int'(v.d));
    waitIdle();
    repeat (4) @(negedge clk);
    chk($sformatf("R10 vec%0d status", idx), statusByte, {1'b0, v.expE, v.expM, 5'b0});
    chk($sformatf("R9 vec%0d intN", idx), intN, !(v.expE || v.expM));
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 cardRst", cardRst, 1'b1);
    chk("R1 busy", busy, 1'b0);
    chk("R1 status", statusByte, 8'h00);
    chk("R1 intN", intN, 1'b1);

    // R2: request with slot inactive is ignored
    ifActive = 1'b0;
    startSeq();
    repeat (2) @(negedge clk);
    chk("R2 inactive cardRst", cardRst, 1'b1);
    chk("R2 inactive busy", busy, 1'b0);
    ifActive = 1'b1;

    // R3/R2/R8: reset-low length with a request while busy, then mute latency
    earlyHi = 0; earlyLo = 10; muteHi = 0; muteLo = 20;
    startSeq();
    chk("R2 accepted cardRst", cardRst, 1'b0);
    chk("R2 accepted busy", busy, 1'b1);
    n = 0;
    while (!cardRst && n < 200) begin
      if (n == 5) warmReq = 1'b1;
      @(posedge clk); @(negedge clk);
      warmReq = 1'b0;
      n++;
    end
    chk("R3 reset low cycles", n, RSTLOW);
    n = 0;
    while (!statusByte[5] && n < 200) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
    chk("R8 mute latency", n, 21);
    chk("R8 busy ends", busy, 1'b0);

    // R9: sticky, then cleared
    repeat (10) @(negedge clk);
    chk("R9 sticky status", statusByte, 8'h20);
    chk("R9 intN low", intN, 1'b0);
    clearStatus();
    chk("R9 cleared", statusByte, 8'h00);
    chk("R9 intN high", intN, 1'b1);

    // table walk
    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R5: flags rise while reset still low, reset returns on time
    earlyLo = 10; muteLo = 20;
    clearStatus();
    startSeq();
    pulseIo(4);
    chk("R5 both flags during reset low", statusByte, 8'h60);
    chk("R5 cardRst still low", cardRst, 1'b0);
    chk("R5 busy still high", busy, 1'b1);
    waitIdle();
    chk("R5 reset released", cardRst, 1'b1);

    // R11: a later IO edge after the decision changes nothing
    clearStatus();
    startSeq();
    while (!cardRst) @(negedge clk);
    pulseIo(12);  // judged at counter 14: no flag
    waitIdle();
    pulseIo(2);
    repeat (30) @(negedge clk);
    chk("R11 later edge ignored", statusByte, 8'h00);
    chk("R11 intN", intN, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule